// File: doc/BRIEF.md
# Multiplexed LCD Frame Timing Generator

This block produces the common-line timing for a multiplexed segment display. It runs on the system clock and takes two single-cycle enable pulses, one at 2048 Hz and one at 128 Hz. A configuration bit picks which of the two pulses drives the timing. A 4-bit divider code sets how many source ticks each common line stays active. A 2-bit multiplex code sets how many common lines take turns.

The block outputs a one-hot active-common vector, a drive-polarity flag that inverts on every frame so that each segment sees zero average DC, and a one-cycle frame strobe. The bias bit passes through to the analog drive stage, which lies outside this block. Every configuration input is sampled once after reset. After that, a new setting is taken only at a frame boundary, so a frame never mixes two settings.

There is no data stream here. All pins are plain control and status signals, so no valid/ready handshake or back-pressure applies.

Top module: `lcd_frame_timer`

## Requirements
- R1: While reset is asserted (rst_n low), com_onehot is 4'b0001, drive_pol is 0 and frame_stb is 0.
- R2: com_onehot always has exactly one bit set.
- R3: With cfg_clk_sel = 0 (2048 Hz source), the active common advances once every 4*(cfg_div+1) pulses of tick_fast. This gives frame rates from 128 Hz down to 8 Hz with four commons.
- R4: With cfg_clk_sel = 1 (128 Hz source), the active common advances once every (cfg_div/4, rounded down)+1 pulses of tick_slow. Codes 0 to 3 all give the fastest slot of one pulse, which is 32 Hz with four commons.
- R5: cfg_mux codes 00, 01, 10 and 11 select 1, 2, 3 and 4 common lines. The active common steps from bit 0 upward and returns to bit 0 after the last active common.
- R6: frame_stb is high for exactly one clock, in the cycle when com_onehot returns to bit 0. With one common line, this happens on every step.
- R7: drive_pol inverts in the same cycle as each frame strobe and holds its value at all other times. It is 0 until the first frame ends.
- R8: Pulses on the tick input that is not selected have no effect on com_onehot, frame_stb or drive_pol.
- R9: A change to cfg_div, cfg_mux or cfg_bias made in the middle of a frame takes effect only when that frame wraps. bias_out shows the bias bit currently in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | One-cycle enable at 2048 Hz |
| tick_slow | input | 1 | One-cycle enable at 128 Hz |
| cfg_clk_sel | input | 1 | Source select: 0 = tick_fast, 1 = tick_slow |
| cfg_div | input | 4 | Frame-rate divider code |
| cfg_mux | input | 2 | Multiplex code: common count minus one |
| cfg_bias | input | 1 | Bias select passed to the analog stage |
| com_onehot | output | 4 | Active common line, one-hot |
| drive_pol | output | 1 | Drive polarity, inverted every frame |
| frame_stb | output | 1 | One-cycle pulse at each frame wrap |
| bias_out | output | 1 | Bias bit latched at the frame boundary |

## Verification
The assertions assume that the configuration inputs are stable during the first clock after reset is released, and that each tick input is a single-cycle pulse. The active-index range check also relies on the multiplex code changing only through the frame-boundary latch.

The stimulus sets up each configuration while reset is held. It then issues each selected tick as a single high cycle followed by a low cycle. It keeps the unselected tick high in every cycle, so that input is always active but must be ignored. Mid-frame configuration changes are made only in the dedicated boundary test.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int DIV_W      = 4;
  localparam int MUX_W      = 2;
  localparam int FAST_SCALE = 4;
  localparam int SLOW_SHIFT = 2;

  typedef struct packed {
    logic             clk_sel;
    logic [DIV_W-1:0] div;
    logic [MUX_W-1:0] mux;
    logic             bias;
  } lcdt_cfg_t;
endpackage

// File: rtl/lcdt_cfg_latch.sv
module lcdt_cfg_latch
  import lcdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lcdt_cfg_t cfg_in,
  input  logic      frame_wrap,
  output lcdt_cfg_t cfg_q,
  output logic      armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      armed <= 1'b0;
    end else begin
      if (!armed || frame_wrap) cfg_q <= cfg_in;
      armed <= 1'b1;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(armed) && !$past(frame_wrap)) |-> $stable(cfg_q)); // R9
endmodule

// File: rtl/lcdt_slot_div.sv
module lcdt_slot_div #(
  parameter int DIV_W      = 4,
  parameter int FAST_SCALE = 4,
  parameter int SLOW_SHIFT = 2,
  localparam int SLOT_W    = $clog2(FAST_SCALE << DIV_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             clk_sel,
  input  logic [DIV_W-1:0] div,
  output logic             slot_end
);
  logic [SLOT_W-1:0] cnt;
  logic [SLOT_W-1:0] slot_max;

  always_comb begin
    if (clk_sel) slot_max = SLOT_W'(div >> SLOW_SHIFT);
    else         slot_max = SLOT_W'(FAST_SCALE * (int'(div) + 1) - 1);
  end

  assign slot_end = run && tick && (cnt == slot_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run)           cnt <= '0;
    else if (slot_end)       cnt <= '0;
    else if (tick)           cnt <= cnt + 1'b1;
  end

  AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= slot_max); // R3
  AST_SLOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt)); // R8
endmodule

// File: rtl/lcdt_com_seq.sv
module lcdt_com_seq #(
  parameter int MUX_W  = 2,
  localparam int COM_N = 1 << MUX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [MUX_W-1:0] last_idx,
  output logic [COM_N-1:0] com_onehot,
  output logic             pol,
  output logic             frame_stb,
  output logic             wrap
);
  logic [MUX_W-1:0] idx;

  assign wrap = step && (idx == last_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      pol       <= 1'b0;
      frame_stb <= 1'b0;
    end else begin
      frame_stb <= wrap;
      if (wrap) begin
        idx <= '0;
        pol <= ~pol;
      end else if (step) begin
        idx <= idx + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < COM_N; g++) begin : g_dec
    assign com_onehot[g] = (idx == MUX_W'(g));
  end

  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_onehot) == 1); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= last_idx); // R5
  AST_STB_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> com_onehot[0]); // R6
  AST_POL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> (pol != $past(pol))); // R7
  AST_POL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |-> $stable(pol)); // R7
endmodule

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
  import lcdt_pkg::*;
#(
  parameter int P_DIV_W  = DIV_W,
  parameter int P_MUX_W  = MUX_W,
  localparam int COM_N   = 1 << P_MUX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_fast,
  input  logic               tick_slow,
  input  logic               cfg_clk_sel,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic [MUX_W-1:0]   cfg_mux,
  input  logic               cfg_bias,
  output logic [COM_N-1:0]   com_onehot,
  output logic               drive_pol,
  output logic               frame_stb,
  output logic               bias_out
);
  lcdt_cfg_t cfg_in, cfg_q;
  logic      armed, sel_tick, slot_end, wrap;

  assign cfg_in = '{clk_sel: cfg_clk_sel, div: cfg_div, mux: cfg_mux, bias: cfg_bias};

  lcdt_cfg_latch u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .frame_wrap(wrap),
    .cfg_q(cfg_q), .armed(armed)
  );

  assign sel_tick = cfg_q.clk_sel ? tick_slow : tick_fast;

  lcdt_slot_div #(.DIV_W(P_DIV_W), .FAST_SCALE(FAST_SCALE), .SLOW_SHIFT(SLOW_SHIFT)) u_div (
    .clk(clk), .rst_n(rst_n), .run(armed), .tick(sel_tick),
    .clk_sel(cfg_q.clk_sel), .div(cfg_q.div), .slot_end(slot_end)
  );

  lcdt_com_seq #(.MUX_W(P_MUX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .step(slot_end), .last_idx(cfg_q.mux),
    .com_onehot(com_onehot), .pol(drive_pol), .frame_stb(frame_stb), .wrap(wrap)
  );

  assign bias_out = cfg_q.bias;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_tick |=> ($stable(com_onehot) && !frame_stb)); // R8
endmodule

// File: tb/sim_lcd_frame_timer.sv
module sim_lcd_frame_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_fast = 1'b0, tick_slow = 1'b0, cfg_clk_sel = 1'b0, cfg_bias = 1'b0;
  logic [3:0] cfg_div = '0;
  logic [1:0] cfg_mux = '0;
  logic [3:0] com_onehot;
  logic drive_pol, frame_stb, bias_out;
  int checks = 0, errors = 0;
  logic [3:0] s_com;
  logic s_pol, s_stb;

  always #5 clk = ~clk;

  lcd_frame_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
    .cfg_clk_sel(cfg_clk_sel), .cfg_div(cfg_div), .cfg_mux(cfg_mux), .cfg_bias(cfg_bias),
    .com_onehot(com_onehot), .drive_pol(drive_pol), .frame_stb(frame_stb), .bias_out(bias_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic sel, input logic [3:0] dv, input logic [1:0] mx, input logic bs);
    @(negedge clk);
    rst_n = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
    cfg_clk_sel = sel; cfg_div = dv; cfg_mux = mx; cfg_bias = bs;
    repeat (2) @(negedge clk);
    chk("R1 com", int'(com_onehot), 1);
    chk("R1 pol", int'(drive_pol), 0);
    chk("R1 stb", int'(frame_stb), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    if (sel) tick_fast = 1'b1; else tick_slow = 1'b1;  // unselected always active
  endtask

  // one selected tick, then one idle cycle; outputs sampled after the tick edge
  task automatic pulse();
    if (cfg_clk_sel) tick_slow = 1'b1; else tick_fast = 1'b1;
    @(posedge clk); @(negedge clk);
    s_com = com_onehot; s_pol = drive_pol; s_stb = frame_stb;
    if (cfg_clk_sel) tick_slow = 1'b0; else tick_fast = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R8 idle com", int'(com_onehot), int'(s_com));
    chk("R8 idle stb", int'(frame_stb), 0);
    chk("R8 idle pol", int'(drive_pol), int'(s_pol));
  endtask

  // issue n ticks and check one slot of behaviour
  task automatic run_slot(input int n, input int exp_idx, input int exp_pol, input int exp_stb, input string req);
    for (int t = 1; t <= n; t++) begin
      pulse();
      if (t < n) begin
        chk({req, " early"}, int'(s_com), -1);
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    join_none

    for (int sel = 0; sel < 2; sel++) begin
      for (int mx = 0; mx < 4; mx++) begin
        for (int dv = 0; dv < 16; dv++) begin
          int slot, ncom, idx, pol;
          slot = sel ? (dv / 4) + 1 : 4 * (dv + 1);
          ncom = mx + 1;
          idx = 0; pol = 0;
          do_reset(sel[0], dv[3:0], mx[1:0], 1'b0);
          for (int k = 1; k <= 2 * ncom; k++) begin
            int prev;
            prev = idx;
            for (int t = 1; t <= slot; t++) begin
              pulse();
              if (t < slot) begin
                chk(sel ? "R4 hold" : "R3 hold", int'(s_com), 1 << prev);
                chk("R6 no stb", int'(s_stb), 0);
              end
            end
            idx = (idx + 1) % ncom;
            if (idx == 0) pol ^= 1;
            chk(sel ? "R4 step" : "R3 step", int'(s_com), 1 << idx);
            chk("R5 wrap", int'(s_com), 1 << idx);
            chk("R6 stb", int'(s_stb), (idx == 0) ? 1 : 0);
            chk("R7 pol", int'(s_pol), pol);
            chk("R2 onehot", $countones(s_com), 1);
          end
        end
      end
    end

    // R9: mid-frame change applies only at the wrap
    do_reset(1'b0, 4'd0, 2'd3, 1'b0);
    repeat (4) pulse();
    chk("R9 first step", int'(s_com), 2);
    cfg_mux = 2'd1; cfg_div = 4'd1; cfg_bias = 1'b1;
    repeat (4) pulse();
    chk("R9 old mux kept", int'(s_com), 4);
    chk("R9 old bias kept", int'(bias_out), 0);
    repeat (4) pulse();
    chk("R9 old slot kept", int'(s_com), 8);
    repeat (4) pulse();
    chk("R9 wrap com", int'(s_com), 1);
    chk("R9 wrap stb", int'(s_stb), 1);
    chk("R9 wrap pol", int'(s_pol), 1);
    chk("R9 new bias", int'(bias_out), 1);
    repeat (7) pulse();
    chk("R9 new slot hold", int'(s_com), 1);
    pulse();
    chk("R9 new slot step", int'(s_com), 2);
    repeat (8) pulse();
    chk("R9 new mux wrap", int'(s_com), 1);
    chk("R9 new mux stb", int'(s_stb), 1);
    chk("R9 pol back", int'(s_pol), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule